// File: doc/BRIEF.md
# Byte-wide SPI Master/Slave Port

This block is an 8-bit synchronous serial port that works either as the clock-driving master or as a slave clocked from outside. Software configures it through a control register that holds an enable bit, a clock idle-level bit and a 4-bit mode code. It moves data through a data register that acts as the transmit load point and the receive buffer. An internal shift register exchanges one byte per transfer, MSB first. The outgoing bit changes on the clock edge that leaves the idle level. The incoming bit is sampled on the edge that returns to it.

As master, a write to the data register starts a transfer. The serial clock comes from the system clock through one of three dividers, or from an external timer tick. As slave, a data write arms the next outgoing byte, and the port shifts on edges of the external clock. Those edges are oversampled through synchronizers. The active-low select input can be honoured or ignored. Two sticky flags report write collisions and slave receive overruns, and software clears each of them by writing 0.

Top module: `spi_port`

## Requirements
- R1: Modes 4'b0000, 4'b0001 and 4'b0010 run as master with a serial clock period of 4, 16 and 64 system clock cycles respectively.
- R2: Mode 4'b0011 runs as master and toggles the serial clock once per `timer_tick_i` pulse, so one clock period spans two ticks.
- R3: Control bit 4 sets the serial clock idle level. When set, the clock idles high; when clear, it idles low. The master's `sck_o` sits at this level whenever no transfer is running.
- R4: Data shifts MSB first. `sdo_o` changes on the edge leaving the idle level and `sdi_i` is sampled on the edge returning to it. After 8 bits `done_o` pulses for exactly one cycle and the received byte is readable at address 1.
- R5: Mode 4'b0101 is a slave that ignores `ss_ni`. In mode 4'b0100, the slave ignores clock edges and holds `sdo_oe_o` low while `ss_ni` is high, and exchanges bytes while `ss_ni` is low.
- R6: In mode 4'b0100, a rising edge of `ss_ni` in the middle of a byte discards the partial bit count, so the next 8 clocks form a complete byte.
- R7: A data write while a transfer is shifting is ignored and sets control bit 7 (write collision). The flag stays set until a control write with bit 7 at 0.
- R8: In slave mode, a byte that completes while the buffer holds unread data sets control bit 6 (overflow), the new byte is lost and the buffer keeps its old value. The flag stays set until a control write with bit 6 at 0.
- R9: The overflow flag never sets in master mode, even when received bytes are never read.
- R10: When the enable bit (control bit 5) is 0, or the mode code is not one of 4'b0000 to 4'b0101, `sck_oe_o` and `sdo_oe_o` are low and data writes start no transfer.
- R11: Address 0 is the control register, with collision in bit 7, overflow in bit 6, enable in bit 5, idle level in bit 4 and mode in bits 3:0. It reads back as written. Address 1 is the data register, and a read there frees the buffer for the next received byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 1 | 0 = control, 1 = data |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, combinational on address |
| timer_tick_i | input | 1 | External timer tick for mode 4'b0011 |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe_o | output | 1 | Drive enable for sck_o |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Drive enable for sdo_o |
| ss_ni | input | 1 | Active-low slave select |
| done_o | output | 1 | One-cycle pulse per completed byte |

## Verification
The assertions assume that slave clock edges alternate between leading and trailing. This means `sck_i` already sits at the idle level whenever the slave is enabled or `ss_ni` toggles. They also assume that `sck_i` and `sdi_i` hold each level for several system clocks, and that the mode is not changed in the middle of a byte. The stimulus keeps to these assumptions. It disables the port before reconfiguring it, parks `sck_i` at the new idle level before re-enabling, and only toggles `ss_ni` while the clock is idle. It also holds every slave clock half-period for 8 system clocks, which is far longer than the synchronizer delay.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  localparam logic [3:0] MODE_DIV_LO   = 4'd0;
  localparam logic [3:0] MODE_DIV_MID  = 4'd1;
  localparam logic [3:0] MODE_DIV_HI   = 4'd2;
  localparam logic [3:0] MODE_TIMER    = 4'd3;
  localparam logic [3:0] MODE_SLV_SEL  = 4'd4;
  localparam logic [3:0] MODE_SLV_FREE = 4'd5;

  typedef struct packed {
    logic       wcol;
    logic       ovf;
    logic       en;
    logic       cpol;
    logic [3:0] mode;
  } ctrl_t;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int         W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[i];
        stab_q <= RST_VAL[i];
      end else begin
        meta_q <= d_i[i];
        stab_q <= meta_q;
      end
    end
    assign q_o[i] = stab_q;
  end

endmodule

// File: rtl/spi_clk_gen.sv
module spi_clk_gen #(
  parameter int DIV_LO  = 4,
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  input  logic       tick_i,
  output logic       lead_o,
  output logic       trail_o,
  output logic       phase_o
);

  localparam int CW = $clog2(DIV_HI / 2) + 1;

  logic [CW-1:0] cnt_q, half;
  logic          phase_q, use_tick, step;

  always_comb begin
    case (sel_i)
      2'd0:    half = CW'(DIV_LO / 2);
      2'd1:    half = CW'(DIV_MID / 2);
      default: half = CW'(DIV_HI / 2);
    endcase
  end

  assign use_tick = (sel_i == 2'd3);
  assign step     = run_i && (use_tick ? tick_i : (cnt_q == half - 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (step) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else if (!use_tick) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign lead_o  = step & ~phase_q;
  assign trail_o = step & phase_q;
  assign phase_o = phase_q;

  // divided clock: two steps are never back to back
  assert_step_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !use_tick && step) |=> !step);

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         lead_i,
  input  logic         trail_i,
  input  logic         sin_i,
  output logic         sout_o,
  output logic         shifting_o,
  output logic         done_o,
  output logic [W-1:0] rx_o
);

  localparam int          CW   = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;
  logic          mid_q, sout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      mid_q  <= 1'b0;
      sout_q <= 1'b0;
    end else begin
      if (load_i) sr_q <= load_data_i;
      if (clear_i) begin
        cnt_q <= '0;
        mid_q <= 1'b0;
      end else if (lead_i) begin
        sout_q <= sr_q[W-1];
        mid_q  <= 1'b1;
      end else if (trail_i) begin
        sr_q  <= {sr_q[W-2:0], sin_i};
        mid_q <= 1'b0;
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
    end
  end

  assign sout_o     = sout_q;
  assign shifting_o = mid_q || (cnt_q != '0);
  assign done_o     = trail_i && !clear_i && (cnt_q == LAST);
  assign rx_o       = {sr_q[W-2:0], sin_i};

  // a sampling edge only ever follows a launching edge
  assert_lead_before_trail_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trail_i && !clear_i) |-> mid_q);

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_LO  = 4,
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              timer_tick_i,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              ss_ni,
  output logic              done_o
);

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] buf_q;
  logic              full_q, busy_q, done_q;
  logic              is_master, is_slave, port_on, ss_honour;

  always_comb begin
    is_master = ctrl_q.en && (ctrl_q.mode <= MODE_TIMER);
    is_slave  = ctrl_q.en && ((ctrl_q.mode == MODE_SLV_SEL) || (ctrl_q.mode == MODE_SLV_FREE));
    ss_honour = (ctrl_q.mode == MODE_SLV_SEL);
    port_on   = is_master || is_slave;
  end

  // slave pins oversampled in the system clock domain
  logic [2:0] pin_s;
  logic       sck_prev_q, ss_prev_q;
  logic       sck_s, ss_s, sdi_s;

  spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_ni, sck_i, sdi_i}),
    .q_o   (pin_s)
  );

  assign sdi_s = pin_s[0];
  assign sck_s = pin_s[1];
  assign ss_s  = pin_s[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev_q <= 1'b0;
      ss_prev_q  <= 1'b1;
    end else begin
      sck_prev_q <= sck_s;
      ss_prev_q  <= ss_s;
    end
  end

  logic ss_ok, s_rise, s_fall, s_lead, s_trail, ss_restart;
  assign ss_ok      = !ss_honour || !ss_s;
  assign s_rise     = sck_s & ~sck_prev_q;
  assign s_fall     = ~sck_s & sck_prev_q;
  assign s_lead     = is_slave && ss_ok && (ctrl_q.cpol ? s_fall : s_rise);
  assign s_trail    = is_slave && ss_ok && (ctrl_q.cpol ? s_rise : s_fall);
  assign ss_restart = is_slave && ss_honour && ss_s && !ss_prev_q;

  // master clock
  logic m_lead, m_trail, m_phase;

  spi_clk_gen #(.DIV_LO(DIV_LO), .DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (is_master && busy_q),
    .sel_i  (ctrl_q.mode[1:0]),
    .tick_i (timer_tick_i),
    .lead_o (m_lead),
    .trail_o(m_trail),
    .phase_o(m_phase)
  );

  // register access
  logic data_wr, ctrl_wr, data_rd;
  assign data_wr = reg_we_i && reg_addr_i;
  assign ctrl_wr = reg_we_i && !reg_addr_i;
  assign data_rd = reg_re_i && reg_addr_i;

  logic              sh_sout, sh_shifting, sh_done;
  logic [DATA_W-1:0] sh_rx;
  logic              in_flight, load, wcol_set, ovf_set;

  assign in_flight = is_master ? busy_q : sh_shifting;
  assign load      = data_wr && !in_flight;
  assign wcol_set  = data_wr && in_flight;
  assign ovf_set   = sh_done && is_slave && full_q && !data_rd;

  spi_shifter #(.W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (!port_on || ss_restart),
    .load_i     (load),
    .load_data_i(reg_wdata_i),
    .lead_i     (is_master ? m_lead : s_lead),
    .trail_i    (is_master ? m_trail : s_trail),
    .sin_i      (is_master ? sdi_i : sdi_s),
    .sout_o     (sh_sout),
    .shifting_o (sh_shifting),
    .done_o     (sh_done),
    .rx_o       (sh_rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      buf_q  <= '0;
      full_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= sh_done;
      if (ctrl_wr) begin
        ctrl_q.en   <= reg_wdata_i[5];
        ctrl_q.cpol <= reg_wdata_i[4];
        ctrl_q.mode <= reg_wdata_i[3:0];
        ctrl_q.wcol <= wcol_set || (ctrl_q.wcol && reg_wdata_i[7]);
        ctrl_q.ovf  <= ovf_set || (ctrl_q.ovf && reg_wdata_i[6]);
      end else begin
        ctrl_q.wcol <= ctrl_q.wcol || wcol_set;
        ctrl_q.ovf  <= ctrl_q.ovf || ovf_set;
      end
      if (!is_master)   busy_q <= 1'b0;
      else if (load)    busy_q <= 1'b1;
      else if (sh_done) busy_q <= 1'b0;
      if (sh_done && !ovf_set) begin
        buf_q  <= sh_rx;
        full_q <= 1'b1;
      end else if (data_rd) begin
        full_q <= 1'b0;
      end
    end
  end

  assign reg_rdata_o = reg_addr_i ? buf_q : DATA_W'(ctrl_q);
  assign sck_oe_o    = is_master;
  assign sck_o       = is_master ? (m_phase ^ ctrl_q.cpol) : ctrl_q.cpol;
  assign sdo_oe_o    = is_master || (is_slave && ss_ok);
  assign sdo_o       = sdo_oe_o ? sh_sout : 1'b0;
  assign done_o      = done_q;

  assert_sck_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_master && !busy_q) |-> (sck_o == ctrl_q.cpol));

  assert_wcol_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.wcol && !(ctrl_wr && !reg_wdata_i[7])) |=> ctrl_q.wcol);

  assert_ovf_keeps_buf_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_q.ovf) |-> $stable(buf_q));

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_q.ovf) |-> $past(is_slave));

  assert_quiet_when_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_on |=> !done_o);

endmodule

// File: tb/spi_port_test.sv
module spi_port_test;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0, reg_re_i = 1'b0, reg_addr_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       timer_tick_i = 1'b0, sck_i = 1'b0, sdi_i = 1'b0, ss_ni = 1'b1;
  logic       sck_o, sck_oe_o, sdo_o, sdo_oe_o, done_o;

  always #10 clk = ~clk;

  spi_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_re_i(reg_re_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .timer_tick_i(timer_tick_i), .sck_i(sck_i), .sck_o(sck_o), .sck_oe_o(sck_oe_o),
    .sdi_i(sdi_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .ss_ni(ss_ni), .done_o(done_o)
  );

  int checks = 0, failures = 0, done_cnt = 0;

  always @(negedge clk) if (done_o === 1'b1) done_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    reg_re_i = 1'b1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(negedge clk);
    reg_re_i = 1'b0;
  endtask

  task automatic master_xfer(input logic [3:0] mode, input logic cpol, input logic [7:0] tx,
                             input logic [7:0] rx, input logic collide,
                             output logic [7:0] got, output int period);
    int cyc, nlead, t0, start;
    logic prev;
    wr(0, 8'h00);
    wr(0, {2'b00, 1'b1, cpol, mode});
    idle(2);
    chk("R3 idle level", sck_o, cpol);
    start = done_cnt; prev = sck_o; nlead = 0; t0 = 0; got = '0; period = 0; cyc = 0;
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = 1'b1; reg_wdata_i = tx;
    while (done_cnt == start && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      reg_we_i     = collide && (cyc == 6);
      reg_wdata_i  = ~tx;
      timer_tick_i = (cyc % 5 == 0);
      if (sck_o !== prev) begin
        if (sck_o !== cpol) begin
          if (nlead == 0) t0 = cyc;
          if (nlead == 1) period = cyc - t0;
          if (nlead < 8) sdi_i = rx[7-nlead];
          nlead++;
        end else begin
          got = {got[6:0], sdo_o};
        end
        prev = sck_o;
      end
    end
    reg_we_i = 1'b0; timer_tick_i = 1'b0;
  endtask

  task automatic slave_cfg(input logic [3:0] mode, input logic cpol);
    wr(0, 8'h00);
    sck_i = cpol; ss_ni = 1'b1;
    idle(5);
    wr(0, {2'b00, 1'b1, cpol, mode});
    idle(2);
  endtask

  task automatic slave_bits(input logic cpol, input logic [7:0] rx, input int nbits,
                            output logic [7:0] got);
    got = '0;
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk);
      sck_i = ~cpol; sdi_i = rx[7-k];
      idle(8);
      got = {got[6:0], sdo_o};
      sck_i = cpol;
      idle(8);
    end
    idle(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d, got, tx, rx;
    int period, start;

    idle(3);
    rst_ni = 1'b1;
    idle(2);
    rd(0, d);
    chk("R11 reset control", d, 8'h00);
    chk("R10 reset sck_oe", sck_oe_o, 0);
    chk("R10 reset sdo_oe", sdo_oe_o, 0);
    chk("R4 reset done", done_o, 0);

    // master sweep: every master mode and both idle levels
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 2; p++) begin
        tx = 8'(8'h5A + m * 29 + p * 113);
        rx = 8'(~tx ^ 8'h3C);
        start = done_cnt;
        master_xfer(4'(m), 1'(p), tx, rx, 1'b0, got, period);
        chk(m < 3 ? "R1 sck period" : "R2 timer period", period, m < 3 ? (4 << (2 * m)) : 10);
        chk("R4 msb-first out", got, tx);
        chk("R4 one done", done_cnt - start, 1);
        idle(1);
        chk("R4 done pulse width", done_o, 0);
        rd(1, d);
        chk("R4 received byte", d, rx);
        rd(0, d);
        chk("R11 control readback", d, {2'b00, 1'b1, 1'(p), 4'(m)});
      end
    end

    // slave sweep: both slave modes, both idle levels, two bytes each
    for (int m = 4; m < 6; m++) begin
      for (int p = 0; p < 2; p++) begin
        for (int b = 0; b < 2; b++) begin
          tx = 8'(8'hC1 + m * 17 + p * 55 + b * 90);
          rx = 8'(tx * 3 + 8'h29);
          slave_cfg(4'(m), 1'(p));
          wr(1, tx);
          if (m == 4) begin ss_ni = 1'b0; idle(4); end
          chk("R5 slave drives sdo", sdo_oe_o, 1);
          start = done_cnt;
          slave_bits(1'(p), rx, 8, got);
          chk("R5 slave out byte", got, tx);
          chk("R4 slave one done", done_cnt - start, 1);
          rd(1, d);
          chk("R5 slave received", d, rx);
          ss_ni = 1'b1;
        end
      end
    end

    // R5: select high masks the clock
    slave_cfg(4'd4, 1'b0);
    wr(1, 8'h5A);
    idle(4);
    chk("R5 sdo released while deselected", sdo_oe_o, 0);
    start = done_cnt;
    slave_bits(1'b0, 8'hFF, 8, got);
    chk("R5 edges ignored while deselected", done_cnt - start, 0);
    ss_ni = 1'b0; idle(4);
    slave_bits(1'b0, 8'h81, 8, got);
    chk("R5 out byte intact after masked edges", got, 8'h5A);
    rd(1, d);
    chk("R5 received after select", d, 8'h81);
    ss_ni = 1'b1;

    // R6: select rising mid-byte restarts the count
    slave_cfg(4'd4, 1'b1);
    wr(1, 8'hE7);
    ss_ni = 1'b0; idle(4);
    slave_bits(1'b1, 8'hFF, 3, got);
    ss_ni = 1'b1; idle(6);
    ss_ni = 1'b0; idle(4);
    start = done_cnt;
    slave_bits(1'b1, 8'h4B, 8, got);
    chk("R6 one done after restart", done_cnt - start, 1);
    rd(1, d);
    chk("R6 byte after restart", d, 8'h4B);
    ss_ni = 1'b1;

    // R8: slave overflow keeps old byte
    slave_cfg(4'd5, 1'b0);
    wr(1, 8'h11);
    slave_bits(1'b0, 8'hC3, 8, got);
    slave_bits(1'b0, 8'h3C, 8, got);
    rd(0, d);
    chk("R8 overflow flag", d[6], 1);
    wr(0, 8'h65);
    rd(0, d);
    chk("R8 overflow sticky on write 1", d[6], 1);
    rd(1, d);
    chk("R8 buffer kept old byte", d, 8'hC3);
    wr(0, 8'h25);
    rd(0, d);
    chk("R8 overflow cleared by write 0", d[6], 0);
    slave_bits(1'b0, 8'h77, 8, got);
    rd(0, d);
    chk("R11 read freed buffer, no overflow", d[6], 0);
    rd(1, d);
    chk("R11 next byte stored", d, 8'h77);

    // R9: master never overflows
    master_xfer(4'd0, 1'b0, 8'h12, 8'hA0, 1'b0, got, period);
    master_xfer(4'd0, 1'b0, 8'h34, 8'hB1, 1'b0, got, period);
    rd(0, d);
    chk("R9 no master overflow", d[6], 0);
    rd(1, d);
    chk("R9 latest master byte", d, 8'hB1);

    // R7: write collision
    master_xfer(4'd1, 1'b0, 8'h96, 8'h0F, 1'b1, got, period);
    chk("R7 colliding write ignored", got, 8'h96);
    rd(0, d);
    chk("R7 collision flag", d[7], 1);
    wr(0, 8'hA1);
    rd(0, d);
    chk("R7 collision sticky on write 1", d[7], 1);
    wr(0, 8'h21);
    rd(0, d);
    chk("R7 collision cleared by write 0", d[7], 0);

    // R10: disabled and reserved codes
    for (int c = 0; c < 3; c++) begin
      d = (c == 0) ? 8'h00 : (c == 1) ? 8'h26 : 8'h2F;
      wr(0, d);
      idle(2);
      chk("R10 sck released", sck_oe_o, 0);
      chk("R10 sdo released", sdo_oe_o, 0);
      start = done_cnt;
      wr(1, 8'h33);
      idle(300);
      chk("R10 no transfer", done_cnt - start, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule